// File: doc/BRIEF.md
# Iterative Half-Adder Recursion Adder with Completion Detection

This block forms the sum of two unsigned operands without a carry chain. Each bit position has only a half adder and a two-input selector. On the cycle a request is taken, the selectors feed the external operands into the half-adder row. On each later cycle they feed back the row's own partial sum and its partial carry, shifted up one place. Bits that need no carry reach their final value in the first pass. Carries move up at least one place per pass. A completion detector watches the stored carry vector and signals the end as soon as every carry bit is zero. The latency therefore depends on the operand values rather than on a fixed worst case.

A client raises `start` with the operands while `busy` is low. It then waits for the single-cycle `done` pulse and reads `sum` and `cout`. These stay unchanged until the next accepted request. The operand width is the parameter `W`.

Top module: `sta_add`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `busy`=0, `done`=0, `sum`=0 and `cout`=0.
- R2: A clock edge with `start`=1 and `busy`=0 captures `op_a` and `op_b`, and `busy` is 1 in the following cycle.
- R3: In the cycle where `done`=1, the value {`cout`,`sum`} equals the (W+1)-bit sum of the operands captured by the accepting edge.
- R4: `done` is high for exactly one cycle. In the cycle after it, both `done` and `busy` are 0.
- R5: If the captured operands share no set bit (`op_a` & `op_b` == 0), `done` is 1 in the first cycle after the accepting edge.
- R6: `done` rises in at most W cycles after the accepting edge. For `op_a` = all ones and `op_b` = 1 it rises in exactly W cycles, with `sum`=0 and `cout`=1.
- R7: A `start` that arrives while `busy`=1 is ignored. The running result is still that of the first operands.
- R8: While `busy`=0 and `start`=0, `sum` and `cout` keep their values whatever the operand inputs do.
- R9: `done` is never 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to add; taken only when idle |
| op_a | input | W | First unsigned operand |
| op_b | input | W | Second unsigned operand |
| busy | output | 1 | An addition is in progress, including the completion cycle |
| done | output | 1 | One-cycle pulse: result is final |
| sum | output | W | Low W bits of the result; held while idle |
| cout | output | 1 | Carry out of the top bit, accumulated over all passes |

## Verification
The checker does not require the operands to be held after the accepting edge. It does assume that `start` and the operands carry defined values at every sampled edge. The cycle-count and result properties assume that a request is only taken while idle. Requests raised during a run are treated as legal and ignored. The stimulus always drives defined values. It raises `start` only at falling edges while the block is idle, except for the deliberate mid-run requests. It changes the operands freely during idle stretches to show that they are not sampled.

// File: rtl/sta_pkg.sv
package sta_pkg;

    // Control state of the recursion engine
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sta_state_e;

endpackage

// File: rtl/sta_opsel.sv
// Row of 2:1 selectors: external operands on the first pass, fed-back
// partial sum and partial carry on every later pass.
module sta_opsel #(
    parameter int W = 4
) (
    input  logic         sel_ext,
    input  logic [W-1:0] ext_x,
    input  logic [W-1:0] ext_y,
    input  logic [W-1:0] fb_x,
    input  logic [W-1:0] fb_y,
    output logic [W-1:0] x,
    output logic [W-1:0] y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign x[i] = sel_ext ? ext_x[i] : fb_x[i];
        assign y[i] = sel_ext ? ext_y[i] : fb_y[i];
    end
endmodule

// File: rtl/sta_ha_row.sv
// One row of half adders. The generate terms are shifted up one place to
// form the next carry vector; the top term leaves as carry_top.
module sta_ha_row #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] psum,
    output logic [W-1:0] pcarry,
    output logic         carry_top
);
    logic [W-1:0] gen;

    for (genvar i = 0; i < W; i++) begin : g_ha
        assign psum[i] = x[i] ^ y[i];
        assign gen[i]  = x[i] & y[i];
        if (i == 0) begin : g_lsb
            assign pcarry[i] = 1'b0;
        end else begin : g_up
            assign pcarry[i] = gen[i-1];
        end
    end

    assign carry_top = gen[W-1];
endmodule

// File: rtl/sta_cdone.sv
// Completion detector: settled when no stored carry bit is set.
module sta_cdone #(
    parameter int W = 4
) (
    input  logic [W-1:0] carry,
    output logic         settled
);
    assign settled = ~|carry;
endmodule

// File: rtl/sta_add.sv
module sta_add #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] sum,
    output logic         cout
);
    import sta_pkg::*;

    typedef struct packed {
        sta_state_e   st;
        logic [W-1:0] s;
        logic [W-1:0] c;
        logic         co;
    } state_t;

    state_t state_d, state_q;

    logic         accept;
    logic         settled;
    logic         carry_top;
    logic [W-1:0] row_x, row_y;
    logic [W-1:0] row_s, row_c;

    assign accept = start && (state_q.st == ST_IDLE);

    sta_opsel #(.W(W)) i_opsel (
        .sel_ext (accept),
        .ext_x   (op_a),
        .ext_y   (op_b),
        .fb_x    (state_q.s),
        .fb_y    (state_q.c),
        .x       (row_x),
        .y       (row_y)
    );

    sta_ha_row #(.W(W)) i_row (
        .x         (row_x),
        .y         (row_y),
        .psum      (row_s),
        .pcarry    (row_c),
        .carry_top (carry_top)
    );

    sta_cdone #(.W(W)) i_cdone (
        .carry   (state_q.c),
        .settled (settled)
    );

    always_comb begin
        state_d = state_q;
        if (accept) begin
            state_d.st = ST_RUN;
            state_d.s  = row_s;
            state_d.c  = row_c;
            state_d.co = carry_top;
        end else if (state_q.st == ST_RUN) begin
            if (settled) begin
                state_d.st = ST_IDLE;
            end else begin
                state_d.s  = row_s;
                state_d.c  = row_c;
                state_d.co = state_q.co | carry_top;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '{st: ST_IDLE, s: '0, c: '0, co: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign busy = (state_q.st == ST_RUN);
    assign done = busy && settled;
    assign sum  = state_q.s;
    assign cout = state_q.co;
endmodule

// File: rtl/sta_add_chk.sv
module sta_add_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] sum,
    input logic         cout
);
    logic [W:0]  exp_q;
    int unsigned cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q <= '0;
            cnt_q <= 0;
        end else if (start && !busy) begin
            exp_q <= {1'b0, op_a} + {1'b0, op_b};
            cnt_q <= 1;
        end else if (busy) begin
            cnt_q <= cnt_q + 1;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!busy && !done && sum == '0 && !cout));

    a_r2_accept: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r3_result: assert property (@(posedge clk) disable iff (rst)
        done |-> ({cout, sum} == exp_q));

    a_r4_one_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    a_r5_disjoint_fast: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && ((op_a & op_b) == '0)) |=> done);

    a_r6_step_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt_q <= W));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(sum) && $stable(cout)));

    a_r9_done_in_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
endmodule

bind sta_add sta_add_chk #(.W(W)) i_sta_add_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .op_a  (op_a),
    .op_b  (op_b),
    .busy  (busy),
    .done  (done),
    .sum   (sum),
    .cout  (cout)
);

// File: tb/test_sta_add.sv
module test_sta_add;
    localparam int NW = 4;
    localparam int WW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          n_start = 1'b0;
    logic [NW-1:0] n_a = '0, n_b = '0;
    logic          n_busy, n_done, n_cout;
    logic [NW-1:0] n_sum;

    logic          w_start = 1'b0;
    logic [WW-1:0] w_a = '0, w_b = '0;
    logic          w_busy, w_done, w_cout;
    logic [WW-1:0] w_sum;

    sta_add #(.W(NW)) i_sta_add (
        .clk(clk), .rst(rst), .start(n_start), .op_a(n_a), .op_b(n_b),
        .busy(n_busy), .done(n_done), .sum(n_sum), .cout(n_cout)
    );

    sta_add #(.W(WW)) i_sta_add_wide (
        .clk(clk), .rst(rst), .start(w_start), .op_a(w_a), .op_b(w_b),
        .busy(w_busy), .done(w_done), .sum(w_sum), .cout(w_cout)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NW:0] ref_n(input logic [NW-1:0] a, b);
        return {1'b0, a} + {1'b0, b};
    endfunction

    function automatic logic [WW:0] ref_w(input logic [WW-1:0] a, b);
        return {1'b0, a} + {1'b0, b};
    endfunction

    // Runs one request on the narrow instance; poke raises a second start mid-run
    task automatic run_n(input logic [NW-1:0] a, b, input bit poke,
                         output int steps, output logic [NW:0] res);
        @(negedge clk);
        n_start = 1'b1; n_a = a; n_b = b;
        @(negedge clk);
        n_start = 1'b0;
        steps = 1;
        check(n_busy == 1'b1, "R2", "busy after accept", longint'(n_busy), 1);
        while (!n_done && steps < 100) begin
            if (poke && steps == 1) begin
                n_start = 1'b1; n_a = ~a; n_b = ~b;
            end
            @(negedge clk);
            n_start = 1'b0;
            steps++;
        end
        check(n_busy == 1'b1, "R9", "busy with done", longint'(n_busy), 1);
        res = {n_cout, n_sum};
        @(negedge clk);
        check(!n_done && !n_busy, "R4", "done/busy after pulse",
              longint'({n_done, n_busy}), 0);
    endtask

    task automatic run_w(input logic [WW-1:0] a, b,
                         output int steps, output logic [WW:0] res);
        @(negedge clk);
        w_start = 1'b1; w_a = a; w_b = b;
        @(negedge clk);
        w_start = 1'b0;
        steps = 1;
        while (!w_done && steps < 200) begin
            @(negedge clk);
            steps++;
        end
        res = {w_cout, w_sum};
        @(negedge clk);
        check(!w_done && !w_busy, "R4", "wide done/busy after pulse",
              longint'({w_done, w_busy}), 0);
    endtask

    initial begin
        int steps;
        logic [NW:0] nres;
        logic [WW:0] wres;
        void'($urandom(32'd1234));

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(!n_busy && !n_done && n_sum == '0 && !n_cout, "R1", "narrow reset",
              longint'({n_busy, n_done, n_cout, n_sum}), 0);
        check(!w_busy && !w_done && w_sum == '0 && !w_cout, "R1", "wide reset",
              longint'({w_busy, w_done, w_cout}), 0);

        // R6: all ones plus one takes exactly W cycles
        run_n('1, 4'd1, 1'b0, steps, nres);
        check(steps == NW, "R6", "narrow worst-case steps", steps, NW);
        check(nres == 5'b10000, "R6", "narrow worst-case result", longint'(nres), 16);

        // R5: disjoint operands finish on the first pass
        run_n(4'b1010, 4'b0101, 1'b0, steps, nres);
        check(steps == 1, "R5", "disjoint steps", steps, 1);
        check(nres == 5'b01111, "R3", "disjoint result", longint'(nres), 15);

        // R7: start during a run is ignored
        run_n('1, 4'd1, 1'b1, steps, nres);
        check(nres == 5'b10000, "R7", "result after mid-run start", longint'(nres), 16);
        check(steps == NW, "R7", "steps after mid-run start", steps, NW);

        // R8: idle outputs hold while operands change
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            n_a = 4'($urandom); n_b = 4'($urandom);
        end
        @(negedge clk);
        check({n_cout, n_sum} == 5'b10000, "R8", "idle hold", longint'({n_cout, n_sum}), 16);

        // R3/R5/R6: exhaustive narrow operands
        for (int a = 0; a < (1 << NW); a++) begin
            for (int b = 0; b < (1 << NW); b++) begin
                run_n(NW'(a), NW'(b), 1'b0, steps, nres);
                check(nres == ref_n(NW'(a), NW'(b)), "R3", "narrow sum",
                      longint'(nres), longint'(ref_n(NW'(a), NW'(b))));
                check(steps <= NW, "R6", "narrow step bound", steps, NW);
                if ((a & b) == 0)
                    check(steps == 1, "R5", "narrow disjoint steps", steps, 1);
            end
        end

        // R6: wide worst case
        run_w('1, 32'd1, steps, wres);
        check(steps == WW, "R6", "wide worst-case steps", steps, WW);
        check(wres == {1'b1, {WW{1'b0}}}, "R6", "wide worst-case result",
              longint'(wres), longint'(ref_w('1, 32'd1)));

        // R3: random wide operands, including sparse ones
        for (int k = 0; k < 300; k++) begin
            logic [WW-1:0] a, b;
            a = $urandom;
            b = $urandom;
            if (k % 5 == 0) b = a ^ $urandom & ~a;
            run_w(a, b, steps, wres);
            check(wres == ref_w(a, b), "R3", "wide sum", longint'(wres), longint'(ref_w(a, b)));
            check(steps <= WW, "R6", "wide step bound", steps, WW);
            if ((a & b) == '0)
                check(steps == 1, "R5", "wide disjoint steps", steps, 1);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule